// File: doc/BRIEF.md
# Single-Channel Block Copy DMA Engine

This block is one DMA channel. Software programs a source address, a destination address, a control word and a start-mode field, then pulses `kick`. The channel copies a counted block of 16-bit or 32-bit units over a simple memory master port. Each unit is one read followed by one write. The source and the destination each have their own step mode, and the destination has an extra mode that reloads its start address at every launch.

At launch the channel first applies a few guard rules. If the two working addresses are equal, it drops its enable bit and moves nothing. If enable and repeat are both clear, it stays idle and clears the start-mode field. If the source step code is the reserved value, it moves nothing and leaves every register alone. Start mode 5 multiplies the unit count by 128. At the end of a transfer without repeat, the channel clears its own enable bit. With repeat set, a later `kick` carries on from the working addresses.

Top module: `dmac_channel`

## Requirements
- R1: After reset, `busy`, `done`, `m_rd_valid` and `m_wr_valid` are low, and all four registers read back as zero.
- R2: The register index selects the register: 0 is source address, 1 is destination address, 2 is control, 3 is start mode (3 bits). `cfg_rd_data` shows the selected register one cycle after `cfg_rd_idx` is presented. Control fields: count in bits CNT_W-1:0, destination step in 22:21, source step in 24:23, repeat in bit 25, 32-bit units in bit 26 (16-bit units when clear), enable in bit 31.
- R3: A `kick` with enable or repeat set launches a transfer. `busy` rises in the cycle after the kick. Each unit is one read and then one write of 4 or 2 bytes, with at most one read outstanding. A 16-bit unit travels in data bits 15:0.
- R4: Step codes are applied after every unit, by 4 bytes for 32-bit units or 2 bytes for 16-bit units. Destination codes: 0 increment, 1 decrement, 2 fixed, 3 increment. Source codes: 0 increment, 1 decrement, 2 fixed.
- R5: A count field of 0 moves 2^CNT_W units.
- R6: With start mode 5, the unit count is the count field times 128.
- R7: If the working source and destination addresses are equal at kick, enable bit 31 is cleared and no unit is moved.
- R8: A source step code of 3 moves no unit and changes no register.
- R9: With enable and repeat both clear, a kick moves nothing and sets start mode to 0.
- R10: Without repeat, start mode is cleared at launch and enable is cleared at the end. With repeat, both are kept, and the next kick continues from the working addresses.
- R11: With destination code 3, every launch restarts the destination at its programmed value.
- R12: `done` is high for exactly one cycle: the cycle after the last write is accepted. `busy` is low from that cycle on.
- R13: Register writes and kicks are ignored while `busy` is high. Source and destination readback always return the programmed values, not the stepped working addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 2 | Register index for the write |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_idx | input | 2 | Register index for readback |
| cfg_rd_data | output | 32 | Registered readback data |
| kick | input | 1 | Start request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| m_rd_valid | output | 1 | Read request valid |
| m_rd_ready | input | 1 | Read request accepted |
| m_rd_addr | output | ADDR_W | Read byte address |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Read data |
| m_wr_valid | output | 1 | Write request valid |
| m_wr_ready | input | 1 | Write request accepted |
| m_wr_addr | output | ADDR_W | Write byte address |
| m_wr_data | output | 32 | Write data |
| m_wide | output | 1 | 1 for a 4-byte unit, 0 for a 2-byte unit |

## Verification
Register readback is due one cycle after the index is driven. The bench drives the index on a falling edge and samples exactly one falling edge later. A launch is judged only after the bench has counted the single `done` pulse at a falling edge. By that time the last write has already landed in the bench memory, so the unit count, the first write address and the whole memory image are compared against a bench model at that point. For kicks that must not launch, the bench waits twenty cycles and then confirms that `busy` never rose, no write occurred and the registers hold their modelled values.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    STEP_INC = 2'd0,
    STEP_DEC = 2'd1,
    STEP_FIX = 2'd2,
    STEP_RLD = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    RI_SRC  = 2'd0,
    RI_DST  = 2'd1,
    RI_CTL  = 2'd2,
    RI_TRIG = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RD    = 2'd1,
    SQ_RWAIT = 2'd2,
    SQ_WR    = 2'd3
  } sq_state_e;

  localparam int CTL_DSTEP_LO = 21;
  localparam int CTL_SSTEP_LO = 23;
  localparam int CTL_RPT      = 25;
  localparam int CTL_WIDE     = 26;
  localparam int CTL_EN       = 31;
  localparam int TRIG_SCALED  = 5;
  localparam int SCALE_SHIFT  = 7;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_idx,
  input  logic              lock,
  input  logic              clr_en,
  input  logic              clr_trig,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [TRIG_W-1:0] trig_q,
  output logic [CNT_W-1:0]  ctl_cnt,
  output logic [1:0]        ctl_dstep,
  output logic [1:0]        ctl_sstep,
  output logic              ctl_rpt,
  output logic              ctl_wide,
  output logic              ctl_en,
  output logic              src_load,
  output logic              dst_load,
  output logic [31:0]       rd_data
);
  logic [31:0] ctl_q;
  logic        wr_ok;

  assign wr_ok     = wr_en && !lock;
  assign src_load  = wr_ok && (wr_idx == RI_SRC);
  assign dst_load  = wr_ok && (wr_idx == RI_DST);
  assign ctl_cnt   = ctl_q[CNT_W-1:0];
  assign ctl_dstep = ctl_q[CTL_DSTEP_LO +: 2];
  assign ctl_sstep = ctl_q[CTL_SSTEP_LO +: 2];
  assign ctl_rpt   = ctl_q[CTL_RPT];
  assign ctl_wide  = ctl_q[CTL_WIDE];
  assign ctl_en    = ctl_q[CTL_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      dst_q   <= '0;
      ctl_q   <= '0;
      trig_q  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_idx)
          RI_SRC:  src_q  <= wr_data[ADDR_W-1:0];
          RI_DST:  dst_q  <= wr_data[ADDR_W-1:0];
          RI_CTL:  ctl_q  <= wr_data;
          default: trig_q <= wr_data[TRIG_W-1:0];
        endcase
      end
      if (clr_en)   ctl_q[CTL_EN] <= 1'b0;
      if (clr_trig) trig_q <= '0;
      case (rd_idx)
        RI_SRC:  rd_data <= 32'(src_q);
        RI_DST:  rd_data <= 32'(dst_q);
        RI_CTL:  rd_data <= ctl_q;
        default: rd_data <= 32'(trig_q);
      endcase
    end
  end
endmodule

// File: rtl/dmac_addr.sv
module dmac_addr
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_val,
  input  logic              adv,
  input  step_e             mode,
  input  logic              wide,
  output logic [ADDR_W-1:0] cur
);
  logic [ADDR_W-1:0] unit_b;
  logic [ADDR_W-1:0] nxt;

  assign unit_b = wide ? ADDR_W'(4) : ADDR_W'(2);

  always_comb begin
    case (mode)
      STEP_DEC: nxt = cur - unit_b;
      STEP_FIX: nxt = cur;
      default:  nxt = cur + unit_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          cur <= '0;
    else if (load)    cur <= load_val;
    else if (restart) cur <= restart_val;
    else if (adv)     cur <= nxt;
  end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        dstep,
  input  logic [1:0]        sstep,
  input  logic              rpt,
  input  logic              wide,
  input  logic              en,
  input  logic [TRIG_W-1:0] trig,
  input  logic [ADDR_W-1:0] src_cur,
  input  logic [ADDR_W-1:0] dst_cur,
  input  logic              m_rd_ready,
  input  logic              m_rvalid,
  input  logic [31:0]       m_rdata,
  input  logic              m_wr_ready,
  output logic              busy,
  output logic              done,
  output logic              clr_en,
  output logic              clr_trig,
  output logic              dst_restart,
  output logic              adv,
  output logic              m_rd_valid,
  output logic              m_wr_valid,
  output logic [31:0]       m_wr_data
);
  localparam int REM_W = CNT_W + 1 + SCALE_SHIFT;

  sq_state_e        state;
  logic [REM_W-1:0] remain;
  logic [CNT_W:0]   base;
  logic [REM_W-1:0] total;
  logic             idle_kick, same, live, rsv, launch, last_wr;

  assign idle_kick = (state == SQ_IDLE) && kick;
  assign same      = (src_cur == dst_cur);
  assign live      = en || rpt;
  assign rsv       = (sstep == 2'b11);
  assign launch    = idle_kick && !same && live && !rsv;
  assign adv       = (state == SQ_WR) && m_wr_ready;
  assign last_wr   = adv && (remain == REM_W'(1));

  assign clr_en      = (idle_kick && same) || (last_wr && !rpt);
  assign clr_trig    = (idle_kick && !same && !live) || (launch && !rpt);
  assign dst_restart = launch && (dstep == STEP_RLD);

  assign base  = (cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt};
  assign total = (trig == TRIG_W'(TRIG_SCALED)) ? (REM_W'(base) << SCALE_SHIFT)
                                                : REM_W'(base);

  assign m_rd_valid = (state == SQ_RD);
  assign m_wr_valid = (state == SQ_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      remain    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      m_wr_data <= '0;
    end else begin
      done <= last_wr;
      case (state)
        SQ_IDLE: if (launch) begin
          remain <= total;
          busy   <= 1'b1;
          state  <= SQ_RD;
        end
        SQ_RD: if (m_rd_ready) state <= SQ_RWAIT;
        SQ_RWAIT: if (m_rvalid) begin
          m_wr_data <= wide ? m_rdata : {16'h0000, m_rdata[15:0]};
          state     <= SQ_WR;
        end
        default: if (m_wr_ready) begin
          remain <= remain - REM_W'(1);
          if (remain == REM_W'(1)) begin
            busy  <= 1'b0;
            state <= SQ_IDLE;
          end else begin
            state <= SQ_RD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_idx,
  input  logic [31:0]       cfg_wr_data,
  input  logic [1:0]        cfg_rd_idx,
  output logic [31:0]       cfg_rd_data,
  input  logic              kick,
  output logic              busy,
  output logic              done,
  output logic              m_rd_valid,
  input  logic              m_rd_ready,
  output logic [ADDR_W-1:0] m_rd_addr,
  input  logic              m_rvalid,
  input  logic [31:0]       m_rdata,
  output logic              m_wr_valid,
  input  logic              m_wr_ready,
  output logic [ADDR_W-1:0] m_wr_addr,
  output logic [31:0]       m_wr_data,
  output logic              m_wide
);
  logic [ADDR_W-1:0] src_q, dst_q, src_cur, dst_cur;
  logic [TRIG_W-1:0] trig_q;
  logic [CNT_W-1:0]  ctl_cnt;
  logic [1:0]        ctl_dstep, ctl_sstep;
  logic              ctl_rpt, ctl_wide, ctl_en;
  logic              src_load, dst_load, clr_en, clr_trig, dst_restart, adv;

  dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
    .rd_idx(cfg_rd_idx), .lock(busy), .clr_en(clr_en), .clr_trig(clr_trig),
    .src_q(src_q), .dst_q(dst_q), .trig_q(trig_q),
    .ctl_cnt(ctl_cnt), .ctl_dstep(ctl_dstep), .ctl_sstep(ctl_sstep),
    .ctl_rpt(ctl_rpt), .ctl_wide(ctl_wide), .ctl_en(ctl_en),
    .src_load(src_load), .dst_load(dst_load), .rd_data(cfg_rd_data)
  );

  dmac_addr #(.ADDR_W(ADDR_W)) u_src_addr (
    .clk(clk), .rst(rst),
    .load(src_load), .load_val(cfg_wr_data[ADDR_W-1:0]),
    .restart(1'b0), .restart_val(src_q),
    .adv(adv), .mode(step_e'(ctl_sstep)), .wide(ctl_wide), .cur(src_cur)
  );

  dmac_addr #(.ADDR_W(ADDR_W)) u_dst_addr (
    .clk(clk), .rst(rst),
    .load(dst_load), .load_val(cfg_wr_data[ADDR_W-1:0]),
    .restart(dst_restart), .restart_val(dst_q),
    .adv(adv), .mode(step_e'(ctl_dstep)), .wide(ctl_wide), .cur(dst_cur)
  );

  dmac_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_seq (
    .clk(clk), .rst(rst), .kick(kick),
    .cnt(ctl_cnt), .dstep(ctl_dstep), .sstep(ctl_sstep),
    .rpt(ctl_rpt), .wide(ctl_wide), .en(ctl_en), .trig(trig_q),
    .src_cur(src_cur), .dst_cur(dst_cur),
    .m_rd_ready(m_rd_ready), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .m_wr_ready(m_wr_ready),
    .busy(busy), .done(done), .clr_en(clr_en), .clr_trig(clr_trig),
    .dst_restart(dst_restart), .adv(adv),
    .m_rd_valid(m_rd_valid), .m_wr_valid(m_wr_valid), .m_wr_data(m_wr_data)
  );

  assign m_rd_addr = src_cur;
  assign m_wr_addr = dst_cur;
  assign m_wide    = ctl_wide;
endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              m_rd_valid,
  input logic              m_rd_ready,
  input logic [ADDR_W-1:0] m_rd_addr,
  input logic              m_wr_valid,
  input logic              m_wr_ready,
  input logic [ADDR_W-1:0] m_wr_addr,
  input logic [31:0]       m_wr_data
);
  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    (m_rd_valid && m_rd_ready) |=> !m_rd_valid);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_rd_valid && !m_rd_ready) |=> (m_rd_valid && $stable(m_rd_addr)));
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_wr_valid && !m_wr_ready) |=> (m_wr_valid && $stable(m_wr_addr) && $stable(m_wr_data)));
  // R3
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_rd_valid && m_wr_valid));
  // R12
  done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!m_rd_valid && !m_wr_valid));
endmodule

bind dmac_channel dmac_channel_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dmac_channel_test.sv
module dmac_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int CW   = 4;
  localparam int MEMB = 8192;

  logic          clk, rst;
  logic          cfg_wr_en;
  logic [1:0]    cfg_wr_idx, cfg_rd_idx;
  logic [31:0]   cfg_wr_data, cfg_rd_data;
  logic          kick, busy, done;
  logic          m_rd_valid, m_rd_ready, m_rvalid;
  logic [AW-1:0] m_rd_addr, m_wr_addr;
  logic [31:0]   m_rdata, m_wr_data;
  logic          m_wr_valid, m_wr_ready, m_wide;

  dmac_channel #(.ADDR_W(AW), .CNT_W(CW), .TRIG_W(3)) uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .kick(kick), .busy(busy), .done(done),
    .m_rd_valid(m_rd_valid), .m_rd_ready(m_rd_ready), .m_rd_addr(m_rd_addr),
    .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .m_wr_valid(m_wr_valid), .m_wr_ready(m_wr_ready), .m_wr_addr(m_wr_addr),
    .m_wr_data(m_wr_data), .m_wide(m_wide)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem    [MEMB];
  logic [7:0] shadow [MEMB];
  int wr_cnt = 0, wr_mark = 0, done_cnt = 0, busy_cnt = 0;
  logic [AW-1:0] first_wr;
  int nchk = 0, nfail = 0;

  function automatic int mi(input logic [AW-1:0] a, input int k);
    return (int'(a) + k) & (MEMB - 1);
  endfunction

  // memory slave, behaves like a registered responder
  always @(posedge clk) begin
    if (rst) begin
      m_rvalid   <= 1'b0;
      m_rd_ready <= 1'b0;
      m_wr_ready <= 1'b0;
      m_rdata    <= '0;
      for (int i = 0; i < MEMB; i++) mem[i] = 8'(i * 7 + 3);
    end else begin
      m_rvalid <= 1'b0;
      if (m_rd_valid && m_rd_ready) begin
        m_rvalid <= 1'b1;
        m_rdata  <= {mem[mi(m_rd_addr,3)], mem[mi(m_rd_addr,2)],
                     mem[mi(m_rd_addr,1)], mem[mi(m_rd_addr,0)]};
      end
      if (m_wr_valid && m_wr_ready) begin
        mem[mi(m_wr_addr,0)] = m_wr_data[7:0];
        mem[mi(m_wr_addr,1)] = m_wr_data[15:8];
        if (m_wide) begin
          mem[mi(m_wr_addr,2)] = m_wr_data[23:16];
          mem[mi(m_wr_addr,3)] = m_wr_data[31:24];
        end
        if (wr_cnt == wr_mark) first_wr = m_wr_addr;
        wr_cnt = wr_cnt + 1;
      end
      m_rd_ready <= ($urandom_range(3) != 0);
      m_wr_ready <= ($urandom_range(3) != 0);
    end
  end

  always @(negedge clk) begin
    if (!rst && done) done_cnt = done_cnt + 1;
    if (!rst && busy) busy_cnt = busy_cnt + 1;
  end

  // bench model state
  logic [31:0]   m_ctl;
  logic [2:0]    m_trig;
  logic [AW-1:0] m_src, m_dst, p_src, p_dst;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int cnt, input int ds, input int ss,
                                     input bit rpt, input bit wide, input bit en);
    logic [31:0] v;
    v = '0;
    v[CW-1:0] = cnt[CW-1:0];
    v[22:21] = ds[1:0];
    v[24:23] = ss[1:0];
    v[25] = rpt;
    v[26] = wide;
    v[31] = en;
    return v;
  endfunction

  task automatic raw_write(input int idx, input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = idx[1:0]; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [31:0] v);
    raw_write(idx, v);
    case (idx)
      0: begin m_src = v[AW-1:0]; p_src = v[AW-1:0]; end
      1: begin m_dst = v[AW-1:0]; p_dst = v[AW-1:0]; end
      2: m_ctl = v;
      default: m_trig = v[2:0];
    endcase
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    cfg_rd_idx = idx[1:0];
    @(negedge clk);
    v = cfg_rd_data;
  endtask

  task automatic pulse_kick;
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic model_kick(output bit go, output int n, output logic [AW-1:0] first);
    int u;
    logic [31:0] d;
    go = 1'b0; n = 0; first = '0; d = '0;
    if (m_src == m_dst) begin
      m_ctl[31] = 1'b0;
    end else if (!m_ctl[31] && !m_ctl[25]) begin
      m_trig = 3'd0;
    end else if (m_ctl[24:23] != 2'd3) begin
      go = 1'b1;
      n = (m_ctl[CW-1:0] == '0) ? (1 << CW) : int'(m_ctl[CW-1:0]);
      if (m_trig == 3'd5) n = n * 128;
      if (!m_ctl[25]) m_trig = 3'd0;
      if (m_ctl[22:21] == 2'd3) m_dst = p_dst;
      first = m_dst;
      u = m_ctl[26] ? 4 : 2;
      for (int i = 0; i < n; i++) begin
        for (int k = 0; k < u; k++) d[k*8 +: 8] = shadow[mi(m_src,k)];
        for (int k = 0; k < u; k++) shadow[mi(m_dst,k)] = d[k*8 +: 8];
        case (m_ctl[22:21])
          2'd1: m_dst = m_dst - AW'(u);
          2'd2: m_dst = m_dst;
          default: m_dst = m_dst + AW'(u);
        endcase
        case (m_ctl[24:23])
          2'd1: m_src = m_src - AW'(u);
          2'd2: m_src = m_src;
          default: m_src = m_src + AW'(u);
        endcase
      end
      if (!m_ctl[25]) m_ctl[31] = 1'b0;
    end
  endtask

  task automatic wait_done(input int d0);
    int t;
    t = 0;
    while (done_cnt == d0 && t < 40000) begin
      @(negedge clk);
      t++;
    end
    if (done_cnt == d0) chk(1'b0, "R12 timeout", 64'(done_cnt), 64'(d0 + 1));
  endtask

  task automatic mem_cmp(input string rq);
    int bad;
    bad = 0;
    for (int i = 0; i < MEMB; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, rq, 64'(bad), 64'd0);
  endtask

  task automatic fire(input string rq);
    bit go;
    int n, w0, d0, b0;
    logic [AW-1:0] f;
    logic [31:0] rb;
    @(negedge clk);
    w0 = wr_cnt; d0 = done_cnt; b0 = busy_cnt;
    wr_mark = w0;
    model_kick(go, n, f);
    pulse_kick();
    if (go) wait_done(d0);
    else repeat (20) @(negedge clk);
    chk((wr_cnt - w0) == n, rq, 64'(wr_cnt - w0), 64'(n));
    chk((done_cnt - d0) == (go ? 1 : 0), "R12", 64'(done_cnt - d0), 64'(go ? 1 : 0));
    if (go) chk(first_wr == f, rq, 64'(first_wr), 64'(f));
    else    chk(busy_cnt == b0, rq, 64'(busy_cnt - b0), 64'd0);
    mem_cmp(rq);
    rd(2, rb);
    chk(rb == m_ctl, rq, 64'(rb), 64'(m_ctl));
    rd(3, rb);
    chk(rb == 32'(m_trig), rq, 64'(rb), 64'(m_trig));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    void'($urandom(32'd4711));
    for (int i = 0; i < MEMB; i++) shadow[i] = 8'(i * 7 + 3);
    m_ctl = '0; m_trig = '0; m_src = '0; m_dst = '0; p_src = '0; p_dst = '0;
    rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_idx = '0; cfg_wr_data = '0;
    cfg_rd_idx = '0; kick = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!busy && !done && !m_rd_valid && !m_wr_valid, "R1",
        64'({busy, done, m_rd_valid, m_wr_valid}), 64'd0);
    for (int i = 0; i < 4; i++) begin
      rd(i, rb);
      chk(rb == 0, "R1", 64'(rb), 64'd0);
    end

    // R2 readback of programmed registers
    prog(0, 32'h0000_0400);
    prog(1, 32'h0000_1000);
    prog(3, 32'd2);
    rd(0, rb); chk(rb == 32'h400, "R2", 64'(rb), 64'h400);
    rd(1, rb); chk(rb == 32'h1000, "R2", 64'(rb), 64'h1000);
    rd(3, rb); chk(rb == 32'd2, "R2", 64'(rb), 64'd2);

    // R3 basic 32-bit increment copy
    prog(2, mk(5, 0, 0, 0, 1, 1));
    fire("R3");
    // R13 programmed address readback unaffected by stepping
    rd(0, rb); chk(rb == 32'h400, "R13", 64'(rb), 64'h400);

    // R4 mixed step modes
    prog(0, 32'h0600); prog(1, 32'h1200); prog(3, 0);
    prog(2, mk(6, 1, 0, 0, 0, 1));
    fire("R4");
    prog(0, 32'h0700); prog(1, 32'h1300);
    prog(2, mk(4, 2, 1, 0, 1, 1));
    fire("R4");
    prog(0, 32'h0710); prog(1, 32'h1380);
    prog(2, mk(3, 0, 2, 0, 0, 1));
    fire("R4");

    // R5 count zero
    prog(0, 32'h0800); prog(1, 32'h1400);
    prog(2, mk(0, 0, 0, 0, 0, 1));
    fire("R5");

    // R6 scaled count
    prog(0, 32'h0900); prog(1, 32'h1600); prog(3, 5);
    prog(2, mk(1, 0, 0, 0, 0, 1));
    fire("R6");

    // R7 same address
    prog(0, 32'h0A00); prog(1, 32'h0A00);
    prog(2, mk(3, 0, 0, 0, 1, 1));
    fire("R7");

    // R8 reserved source step
    prog(1, 32'h1A00);
    prog(2, mk(3, 0, 3, 0, 1, 1));
    fire("R8");

    // R9 enable and repeat clear
    prog(3, 5);
    prog(2, mk(3, 0, 0, 0, 1, 0));
    fire("R9");

    // R10 repeat continues from working addresses
    prog(0, 32'h0B00); prog(1, 32'h1B00); prog(3, 2);
    prog(2, mk(3, 0, 0, 1, 1, 1));
    fire("R10");
    fire("R10");

    // R11 destination reload on each launch
    prog(0, 32'h0C00); prog(1, 32'h1C00);
    prog(2, mk(3, 3, 0, 1, 1, 1));
    fire("R11");
    fire("R11");

    // R13 writes and kicks during busy are ignored
    begin
      bit go; int n, w0, d0; logic [AW-1:0] f;
      prog(0, 32'h0400); prog(1, 32'h1000); prog(3, 5);
      prog(2, mk(2, 0, 0, 0, 0, 1));
      @(negedge clk);
      w0 = wr_cnt; d0 = done_cnt; wr_mark = w0;
      model_kick(go, n, f);
      pulse_kick();
      repeat (10) @(negedge clk);
      raw_write(0, 32'h0600);
      pulse_kick();
      wait_done(d0);
      repeat (25) @(negedge clk);
      chk((wr_cnt - w0) == n, "R13", 64'(wr_cnt - w0), 64'(n));
      rd(0, rb); chk(rb == 32'h400, "R13", 64'(rb), 64'h400);
      mem_cmp("R13");
    end

    // R3 randomised transfers
    for (int it = 0; it < 24; it++) begin
      prog(0, 32'h0400 + 32'($urandom_range(255)) * 4);
      prog(1, 32'h1000 + 32'($urandom_range(255)) * 4);
      prog(3, 32'($urandom_range(4)));
      prog(2, mk(int'($urandom_range(15)), int'($urandom_range(3)), int'($urandom_range(2)),
                 1'($urandom_range(1)), 1'($urandom_range(1)), 1'b1));
      fire("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule